// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Register Block

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Configuration software writes a 32-bit word with byte enables: the low half addresses slot control, the high half addresses slot status. The slot side reports three things: a card insert or remove request, an attention button press, and the message-interrupt enable flags of the function. The block keeps the event status bits and combines them with the enables into a single notification condition. When that condition changes, the block issues either a message request that carries a vector number or a level on the legacy INTx line.

A small sequencer orders the work after each register change. It has four states:
- `ST_IDLE`: waiting.
- `ST_CMD`: entered after any write that touches slot control. It compares the condition and raises command-completed.
- `ST_EVAL`: entered after a newly raised event. It compares the condition and signals the change.
- `ST_SYNC`: entered after a status-only write. It takes the new condition silently.

From any state the next state is chosen in this order: a control write leads to `ST_CMD`; otherwise a new event leads to `ST_EVAL`; otherwise a status write leads to `ST_SYNC`; otherwise the sequencer returns to `ST_IDLE`. A write-only interlock command bit toggles the interlock-engaged status, and while that status is set, insert and remove requests are refused.

Top module: `hpslot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x03C0: both indicator fields (bits 7:6 attention, bits 9:8 power) hold 2'b11 (off), and every enable is 0. Slot status reads 0x0000, `intx` is 0 and `msg_req` is 0.
- R2: The notification condition is true only when control bit 5 (hot-plug interrupt enable) is 1 and, for some supported event bit k in 0..4, both status bit k and control bit k are 1. The event bits are: 0 attention button, 1 power fault, 2 sensor change, 3 presence change, 4 command completed.
- R3: An interrupt action happens only when the condition differs from the stored previous value, which resets to 0. If `msix_en` is 1, a message is requested with `msg_msix`=1. Otherwise, if `msi_en` is 1, a message is requested with `msg_msix`=0. Otherwise `intx` takes the new condition value. A requested message carries the `vec_num` value present at that time.
- R4: An event whose status bit is already 1 causes no new interrupt action.
- R5: A write with `wr_be[2]` set clears status bits 4:0 wherever `wr_data[20:16]` is 1. The condition is then taken without a message. If neither message mode is enabled and the condition is false, `intx` drops to 0.
- R6: Any write with `wr_be[0]` or `wr_be[1]` set is one command. The condition is compared after the write, then status bit 4 is set two cycles after the write edge. If bit 4 was 0, the condition is compared again.
- R7: Control bit 11 always reads 0. Writing 1 to it toggles status bit 7 (interlock engaged).
- R8: An accepted request sets status bit 6 to `slot_req_insert` and sets status bit 3. While status bit 7 is 1, a request changes nothing and `busy_err` pulses for one cycle.
- R9: `btn_press` sets status bit 0.
- R10: `msg_req` stays high until `msg_ready` is seen. A second request raised while one is pending merges into it, and the later vector is kept.
- R11: An event and a clearing write to the same status bit in the same cycle leave the bit set. An event arriving in the same cycle as a control write is included in that command's comparison.
- R12: Only control bits 0, 3, 4, 5, 7:6 and 9:8 are stored, and only in bytes whose enable is set. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_be | input | 4 | Byte enables; 1:0 control, 3:2 status |
| wr_data | input | 32 | Write data; 15:0 control, 31:16 status |
| slot_req | input | 1 | Card insert/remove request pulse |
| slot_req_insert | input | 1 | 1 = insert, 0 = remove |
| btn_press | input | 1 | Attention button press pulse |
| msi_en | input | 1 | MSI enabled |
| msix_en | input | 1 | MSI-X enabled |
| vec_num | input | 5 | Interrupt message number |
| msg_ready | input | 1 | Message request accepted |
| ctl_rd | output | 16 | Slot control read value |
| sts_rd | output | 16 | Slot status read value |
| busy_err | output | 1 | Request refused while interlocked |
| msg_req | output | 1 | Message request pending |
| msg_msix | output | 1 | Pending message is MSI-X |
| msg_vec | output | 5 | Vector of the pending message |
| intx | output | 1 | Legacy interrupt level |

## Verification
Two cases drive a slot event into the same clock edge as a configuration write.

The first case drives a button press together with a clearing write to that same status bit. The bench then checks that the bit is still set and that no interrupt action follows.

The second case drives a button press together with a control write. The bench checks that the command's comparison already includes the new event, so the message count and `intx` match a reference that applies both changes before comparing.

Random operations also mix clears, events and control writes in single cycles, and the reference predicts each of them.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
    localparam int REG_W   = 16;
    localparam int NUM_EV  = 5;
    localparam int VEC_W_D = 5;

    // status bit positions
    localparam int EV_ATTN    = 0;
    localparam int EV_PWRF    = 1;
    localparam int EV_SENS    = 2;
    localparam int EV_PRES    = 3;
    localparam int EV_CMDC    = 4;
    localparam int ST_PRESENT = 6;
    localparam int ST_LOCK    = 7;

    // control bit positions
    localparam int CT_HPIE    = 5;
    localparam int CT_LOCKCMD = 11;

    localparam logic [REG_W-1:0] CTL_WMASK = 16'h03F9;
    localparam logic [REG_W-1:0] CTL_RESET = 16'h03C0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_EVAL,
        ST_SYNC
    } hp_state_e;
endpackage

// File: rtl/hpslot_regs.sv
module hpslot_regs
    import hpslot_pkg::*;
#(
    parameter logic [NUM_EV-1:0] EV_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_be,
    input  logic [2*REG_W-1:0] wr_data,
    input  logic               slot_req,
    input  logic               slot_req_insert,
    input  logic               btn_press,
    input  logic               set_cmdc,
    output logic [REG_W-1:0]   ctl_q,
    output logic [REG_W-1:0]   sts_q,
    output logic               ctl_hit,
    output logic               sts_hit,
    output logic               ev_new,
    output logic               cc_new,
    output logic               busy_err
);
    localparam int CTL_BYTES = REG_W / 8;

    logic [REG_W-1:0]  ctl_d;
    logic [REG_W-1:0]  sts_d;
    logic [NUM_EV-1:0] w1c;
    logic [NUM_EV-1:0] ext_set;
    logic [NUM_EV-1:0] cmd_set;
    logic              lock_cmd;
    logic              req_ok;
    logic              unused_hi;

    assign ctl_hit  = wr_en && (wr_be[0] || wr_be[1]);
    assign sts_hit  = wr_en && (wr_be[2] || wr_be[3]);
    assign lock_cmd = wr_en && wr_be[1] && wr_data[CT_LOCKCMD];
    assign req_ok   = slot_req && !sts_q[ST_LOCK];
    assign w1c      = (wr_en && wr_be[2]) ? wr_data[REG_W +: NUM_EV] : '0;
    assign unused_hi = ^wr_data[2*REG_W-1:REG_W+NUM_EV];

    for (genvar b = 0; b < CTL_BYTES; b++) begin : g_lane
        assign ctl_d[8*b +: 8] = (wr_en && wr_be[b])
                               ? (wr_data[8*b +: 8] & CTL_WMASK[8*b +: 8])
                               : ctl_q[8*b +: 8];
    end

    always_comb begin
        ext_set          = '0;
        ext_set[EV_ATTN] = btn_press;
        ext_set[EV_PRES] = req_ok;
        ext_set          = ext_set & EV_MASK;
        cmd_set          = '0;
        cmd_set[EV_CMDC] = set_cmdc;
        cmd_set          = cmd_set & EV_MASK;
    end

    assign ev_new = |(ext_set & ~sts_q[NUM_EV-1:0]);
    assign cc_new = |(cmd_set & ~sts_q[NUM_EV-1:0]);

    always_comb begin
        sts_d = sts_q;
        sts_d[NUM_EV-1:0] = (sts_q[NUM_EV-1:0] & ~w1c) | ext_set | cmd_set;
        if (req_ok)   sts_d[ST_PRESENT] = slot_req_insert;
        if (lock_cmd) sts_d[ST_LOCK]    = !sts_q[ST_LOCK];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= CTL_RESET;
            sts_q    <= '0;
            busy_err <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            sts_q    <= sts_d;
            busy_err <= slot_req && sts_q[ST_LOCK];
        end
    end
endmodule

// File: rtl/hpslot_fsm.sv
module hpslot_fsm
    import hpslot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_hit,
    input  logic sts_hit,
    input  logic ev_new,
    input  logic cc_new,
    input  logic cond,
    output logic set_cmdc,
    output logic fire,
    output logic do_sync
);
    hp_state_e state_q;
    hp_state_e state_d;
    logic      prev_q;
    logic      do_cmp;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (ctl_hit)              state_d = ST_CMD;
        else if (ev_new || cc_new) state_d = ST_EVAL;
        else if (sts_hit)         state_d = ST_SYNC;
        else                      state_d = ST_IDLE;
    end

    always_comb begin
        set_cmdc = 1'b0;
        do_cmp   = 1'b0;
        do_sync  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CMD:  begin set_cmdc = 1'b1; do_cmp = 1'b1; end
            ST_EVAL: do_cmp  = 1'b1;
            ST_SYNC: do_sync = 1'b1;
        endcase
    end

    assign fire = do_cmp && (cond != prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n)                prev_q <= 1'b0;
        else if (fire || do_sync)  prev_q <= cond;
    end
endmodule

// File: rtl/hpslot_irq.sv
module hpslot_irq #(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             do_sync,
    input  logic             cond,
    input  logic             msi_en,
    input  logic             msix_en,
    input  logic [VEC_W-1:0] vec_num,
    input  logic             msg_ready,
    output logic             msg_req,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    logic msg_mode;
    assign msg_mode = msi_en || msix_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_req  <= 1'b0;
            msg_msix <= 1'b0;
            msg_vec  <= '0;
        end else if (fire && msg_mode) begin
            msg_req  <= 1'b1;
            msg_msix <= msix_en;
            msg_vec  <= vec_num;
        end else if (msg_req && msg_ready) begin
            msg_req  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               intx <= 1'b0;
        else if (fire && !msg_mode)               intx <= cond;
        else if (do_sync && !msg_mode && !cond)   intx <= 1'b0;
    end
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
    import hpslot_pkg::*;
#(
    parameter int                VEC_W   = VEC_W_D,
    parameter logic [NUM_EV-1:0] EV_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_be,
    input  logic [2*REG_W-1:0] wr_data,
    input  logic               slot_req,
    input  logic               slot_req_insert,
    input  logic               btn_press,
    input  logic               msi_en,
    input  logic               msix_en,
    input  logic [VEC_W-1:0]   vec_num,
    input  logic               msg_ready,
    output logic [REG_W-1:0]   ctl_rd,
    output logic [REG_W-1:0]   sts_rd,
    output logic               busy_err,
    output logic               msg_req,
    output logic               msg_msix,
    output logic [VEC_W-1:0]   msg_vec,
    output logic               intx
);
    logic ctl_hit, sts_hit, ev_new, cc_new;
    logic set_cmdc, fire, do_sync, cond;

    hpslot_regs #(.EV_MASK(EV_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .slot_req(slot_req),
        .slot_req_insert(slot_req_insert), .btn_press(btn_press),
        .set_cmdc(set_cmdc), .ctl_q(ctl_rd), .sts_q(sts_rd),
        .ctl_hit(ctl_hit), .sts_hit(sts_hit), .ev_new(ev_new),
        .cc_new(cc_new), .busy_err(busy_err)
    );

    assign cond = ctl_rd[CT_HPIE] &&
                  |(sts_rd[NUM_EV-1:0] & ctl_rd[NUM_EV-1:0] & EV_MASK);

    hpslot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_hit(ctl_hit), .sts_hit(sts_hit),
        .ev_new(ev_new), .cc_new(cc_new), .cond(cond),
        .set_cmdc(set_cmdc), .fire(fire), .do_sync(do_sync)
    );

    hpslot_irq #(.VEC_W(VEC_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .fire(fire), .do_sync(do_sync),
        .cond(cond), .msi_en(msi_en), .msix_en(msix_en),
        .vec_num(vec_num), .msg_ready(msg_ready), .msg_req(msg_req),
        .msg_msix(msg_msix), .msg_vec(msg_vec), .intx(intx)
    );
endmodule

// File: rtl/hpslot_ctrl_chk.sv
module hpslot_ctrl_chk #(
    parameter int VEC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_be,
    input logic [31:0]      wr_data,
    input logic             slot_req,
    input logic             msi_en,
    input logic             msix_en,
    input logic             msg_ready,
    input logic [15:0]      sts_rd,
    input logic             busy_err,
    input logic             msg_req
);
    // R10: a pending request is held until accepted
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ready) |=> msg_req);

    // R3: a message is only requested in a message mode
    a_r3_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(msi_en || msix_en));

    // R7: interlock command toggles the engaged bit
    a_r7_lock_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[1] && wr_data[11]) |=> (sts_rd[7] != $past(sts_rd[7])));

    // R8: refused request leaves presence untouched and flags busy
    a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && sts_rd[7]) |=> (busy_err && $stable(sts_rd[6])));

    // R6: command completed is set two cycles after a control write
    a_r6_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_be[0] || wr_be[1])) |-> ##2 sts_rd[4]);
endmodule

bind hpslot_ctrl hpslot_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .slot_req(slot_req), .msi_en(msi_en),
    .msix_en(msix_en), .msg_ready(msg_ready), .sts_rd(sts_rd),
    .busy_err(busy_err), .msg_req(msg_req)
);

// File: tb/hpslot_ctrl_bench.sv
module hpslot_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        slot_req = 1'b0, slot_req_insert = 1'b0, btn_press = 1'b0;
    logic        msi_en = 1'b0, msix_en = 1'b0, msg_ready = 1'b1;
    logic [4:0]  vec_num = '0;
    logic [15:0] ctl_rd, sts_rd;
    logic        busy_err, msg_req, msg_msix, intx;
    logic [4:0]  msg_vec;

    always #4 clk = ~clk;

    hpslot_ctrl u_hpslot_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .slot_req(slot_req),
        .slot_req_insert(slot_req_insert), .btn_press(btn_press),
        .msi_en(msi_en), .msix_en(msix_en), .vec_num(vec_num),
        .msg_ready(msg_ready), .ctl_rd(ctl_rd), .sts_rd(sts_rd),
        .busy_err(busy_err), .msg_req(msg_req), .msg_msix(msg_msix),
        .msg_vec(msg_vec), .intx(intx)
    );

    int checks = 0, bad = 0, hs_cnt = 0;
    always @(posedge clk) if (rst_n && msg_req && msg_ready) hs_cnt++;

    // reference state
    logic [15:0] m_ctl = 16'h03C0, m_sts = '0;
    bit m_prev = 0, m_intx = 0, m_busy = 0, m_msix = 0, busy_seen = 0;
    int m_msgs = 0;
    logic [4:0] m_vec = '0;

    function automatic bit m_cond();
        return m_ctl[5] && ((m_sts[4:0] & m_ctl[4:0]) != 5'd0);
    endfunction

    task automatic m_notify();
        bit c = m_cond();
        if (c != m_prev) begin
            m_prev = c;
            if (msix_en || msi_en) begin
                m_msgs++; m_vec = vec_num; m_msix = msix_en;
            end else m_intx = c;
        end
    endtask

    task automatic m_apply(bit wr, logic [31:0] d, logic [3:0] be, bit btn, bit req, bit ins);
        logic [15:0] old = m_sts;
        bit ctlhit = wr && (be[0] || be[1]);
        bit stshit = wr && (be[2] || be[3]);
        bit evnew = 0;
        m_busy = 0;
        if (wr && be[0]) m_ctl[7:0] = d[7:0] & 8'hF9;
        if (wr && be[1]) begin
            m_ctl[15:8] = d[15:8] & 8'h03;
            if (d[11]) m_sts[7] = ~m_sts[7];
        end
        if (wr && be[2]) m_sts[4:0] = m_sts[4:0] & ~d[20:16];
        if (btn) begin evnew |= !old[0]; m_sts[0] = 1'b1; end
        if (req) begin
            if (old[7]) m_busy = 1;
            else begin m_sts[6] = ins; evnew |= !old[3]; m_sts[3] = 1'b1; end
        end
        if (ctlhit) begin
            m_notify();
            if (!m_sts[4]) begin m_sts[4] = 1'b1; m_notify(); end
        end else if (evnew) begin
            m_notify();
        end else if (stshit) begin
            m_prev = m_cond();
            if (!msi_en && !msix_en && !m_prev) m_intx = 0;
        end
    endtask

    task automatic op(bit wr, logic [31:0] d, logic [3:0] be, bit btn, bit req, bit ins);
        @(negedge clk);
        wr_en = wr; wr_data = d; wr_be = be;
        btn_press = btn; slot_req = req; slot_req_insert = ins;
        m_apply(wr, d, be, btn, req, ins);
        @(negedge clk);
        busy_seen = busy_err;
        wr_en = 0; wr_be = '0; btn_press = 0; slot_req = 0; slot_req_insert = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " ctl"}, ctl_rd, m_ctl);
        chk({req, " sts"}, sts_rd, m_sts);
        chk({req, " intx"}, intx, m_intx);
        chk({req, " msgs"}, hs_cnt, m_msgs);
        chk({req, " busy"}, busy_seen, m_busy);
        if (m_msgs > 0) begin
            chk({req, " vec"}, msg_vec, m_vec);
            chk({req, " msix"}, msg_msix, m_msix);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int base;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 ctl", ctl_rd, 16'h03C0);
        chk("R1 sts", sts_rd, 16'h0000);
        chk("R1 intx", intx, 0);
        chk("R1 msg_req", msg_req, 0);

        // R12 write masks, R7 lock toggle, R6 command completed
        op(1, 32'h0000FFFF, 4'b0011, 0, 0, 0);
        chk_all("R12");
        chk("R12 ctl", ctl_rd, 16'h03F9);
        chk("R7 bit11 reads 0", ctl_rd[11], 0);
        chk("R7 lock set", sts_rd[7], 1);
        chk("R6 cc set", sts_rd[4], 1);
        chk("R6 intx on cc", intx, 1);

        // R8 refused while locked
        op(0, 0, 0, 0, 1, 1);
        chk_all("R8");
        chk("R8 busy", busy_seen, 1);
        chk("R8 presence kept", sts_rd[6], 0);

        // R7 unlock with high byte only
        op(1, 32'h00000BF9, 4'b0010, 0, 0, 0);
        chk_all("R7");
        chk("R7 unlocked", sts_rd[7], 0);

        // R8 insert then remove
        op(0, 0, 0, 0, 1, 1);
        chk_all("R8");
        chk("R8 present", sts_rd[6], 1);
        chk("R8 pdc", sts_rd[3], 1);
        op(0, 0, 0, 0, 1, 0);
        chk("R8 removed", sts_rd[6], 0);

        // R5 clear all events
        op(1, 32'h001F0000, 4'b0100, 0, 0, 0);
        chk_all("R5");
        chk("R5 intx low", intx, 0);
        chk("R5 events clear", sts_rd[4:0], 0);

        // R9 button raises event, R2 condition
        op(0, 0, 0, 1, 0, 0);
        chk_all("R9");
        chk("R9 attn bit", sts_rd[0], 1);
        chk("R2 intx on", intx, 1);
        op(1, 32'h000003DF, 4'b0011, 0, 0, 0);
        chk_all("R2");
        chk("R2 intx off without enable", intx, 0);

        // R10 hold and merge
        op(1, 32'h000003E1, 4'b0011, 0, 0, 0);
        op(1, 32'h001F0000, 4'b0100, 0, 0, 0);
        chk_all("R10 setup");
        msi_en = 1; msg_ready = 0; vec_num = 5'd7;
        base = hs_cnt;
        op(0, 0, 0, 1, 0, 0);
        chk("R10 req up", msg_req, 1);
        chk("R3 vector", msg_vec, 5'd7);
        chk("R3 msi kind", msg_msix, 0);
        vec_num = 5'd9;
        op(1, 32'h000003C1, 4'b0011, 0, 0, 0);
        chk("R10 held", msg_req, 1);
        chk("R10 none taken", hs_cnt, base);
        chk("R10 later vector", msg_vec, 5'd9);
        msg_ready = 1;
        repeat (3) @(negedge clk);
        chk("R10 one taken", hs_cnt, base + 1);
        chk("R10 req down", msg_req, 0);
        m_msgs = hs_cnt;

        // R3 MSI-X over MSI
        msix_en = 1; vec_num = 5'd3;
        op(1, 32'h000003E1, 4'b0011, 0, 0, 0);
        chk_all("R3");
        chk("R3 msix kind", msg_msix, 1);

        // R4 repeated event ignored
        base = hs_cnt;
        op(0, 0, 0, 1, 0, 0);
        chk_all("R4");
        chk("R4 no new msg", hs_cnt, base);

        // R11 same-cycle clear and press, press with control write
        op(1, 32'h00010000, 4'b0100, 1, 0, 0);
        chk_all("R11");
        chk("R11 attn kept", sts_rd[0], 1);
        msi_en = 0; msix_en = 0;
        op(1, 32'h00010000, 4'b0100, 0, 0, 0);
        op(1, 32'h000003C1, 4'b0001, 0, 0, 0);
        op(1, 32'h000003E1, 4'b0001, 1, 0, 0);
        chk_all("R11 press with command");
        chk("R11 intx", intx, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d = $urandom;
            logic [3:0]  be = 4'($urandom % 16);
            bit wr = ($urandom % 2) == 0;
            bit btn = ($urandom % 10) < 3;
            bit req = ($urandom % 10) < 3;
            bit ins = ($urandom % 2) == 0;
            if (($urandom % 4) != 0) d[11] = 1'b0;
            msi_en  = ($urandom % 3) == 0;
            msix_en = ($urandom % 4) == 0;
            vec_num = 5'($urandom % 32);
            op(wr, d, be, btn, req, ins);
            chk_all("R2 random");
        end
        finish_run();
    end
endmodule